// File: doc/BRIEF.md
# Two-Table Configurable Logic Cell

This block is one logic cell of a small soft programmable fabric. It holds two 4-input truth tables, a 3-input combining table and two storage elements. The behaviour of all of these is set by a single configuration word. That word is shifted in serially and applied as a whole on a commit pulse. Either 4-input table can instead serve as a 16x1 writable memory, addressed by the same four inputs it reads from.

The whole cell runs on one system clock. The fabric clock `fab_clk` is sampled as data. A flip-flop element updates when the sampled fabric clock moves to its active level. A latch element passes its data straight through while that level is held and the clock enable is high. Set and reset share one control input. Configuration chooses, per element, whether that control acts at once (asynchronous) or only on an enabled update (synchronous), and whether it forces a 1 or a 0.

Top module: `clb_dual_lut`

## Requirements
- R1: While `cfg_load` is high, each clock shifts `cfg_sdi` into a 56-bit shadow word. The new bit enters at bit 55 and all bits move one place toward bit 0, so bit 0 is sent first. The shadow has no effect on the outputs until a commit. It holds its value while `cfg_load` is low.
- R2: A one-cycle `cfg_commit` copies the shadow word into the active word, which becomes visible from the next cycle on. The active-word layout is as follows. Bits 15:0 hold the F table. Bits 31:16 hold the G table. Bits 39:32 hold the H table. Bit 40 puts F in RAM mode and bit 41 puts G in RAM mode. Bit 42 selects H (instead of F) on `x`, and bit 43 selects H (instead of G) on `y`. Storage-element fields of 6 bits start at bit 44 for `xq` and at bit 50 for `yq`. Commit takes priority over a RAM write in the same cycle.
- R3: The F result is F-table bit `f_in`, and the G result is G-table bit `g_in`. Both are combinational.
- R4: The H result is H-table bit {`h_in`, G, F}. `x` carries F or H and `y` carries G or H, as set by bits 42 and 43.
- R5: In RAM mode, a clock with `ram_we` high writes `ram_din` into the table bit addressed by that table's inputs. The new value is read from the next cycle. In logic mode, `ram_we` leaves the table unchanged.
- R6: Element field bit 0 is 0 for flip-flop mode. In that mode, the element loads its data when the sampled `fab_clk` goes to the active level and `clk_en` is high. The active level is high, or low when field bit 1 (invert) is set.
- R7: Element field bit 0 is 1 for latch mode. In that mode, the output follows the data while `fab_clk` is at the active level and `clk_en` is high. Otherwise the output holds the last value passed.
- R8: Element field bits 3:2 pick the data source: 0 is `ram_din`, 1 is F, 2 is G, 3 is H.
- R9: When field bit 4 is 1 (asynchronous), `sr` high forces the output to field bit 5 in the same cycle. This overrides the clock and the enable.
- R10: When field bit 4 is 0 (synchronous), `sr` replaces the data with field bit 5. This happens only on an enabled update, as defined in R6 and R7.
- R11: After reset the active and shadow words and both storage elements are 0, so all four outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_load | input | 1 | Shift enable for the configuration shadow |
| cfg_sdi | input | 1 | Serial configuration data, bit 0 first |
| cfg_commit | input | 1 | Copies shadow into the active configuration |
| f_in | input | 4 | F table inputs / RAM address |
| g_in | input | 4 | G table inputs / RAM address |
| h_in | input | 1 | Third input of the H table |
| ram_din | input | 1 | RAM write data and storage data source 0 |
| ram_we | input | 1 | RAM write enable |
| fab_clk | input | 1 | Fabric clock, sampled on `clk` |
| clk_en | input | 1 | Storage clock enable |
| sr | input | 1 | Shared set/reset control |
| x | output | 1 | Combinational output (F or H) |
| y | output | 1 | Combinational output (G or H) |
| xq | output | 1 | Storage element 0 output |
| yq | output | 1 | Storage element 1 output |

## Verification
On every cycle, the assertions check the following properties. The shadow holds without `cfg_load`. A commit copies the shadow exactly. The active word changes only through a commit or a write. A RAM write lands at the address it used. An asynchronous set/reset forces the output at once. A flip-flop element holds whenever it sees no enabled edge. The bench reference model covers what needs whole scenarios: the latch's transparent and holding phases across enable changes, inverted clock polarities, each data source, H combining through both outputs, and synchronous set/reset meeting an enabled edge. It does this with three configurations under random stimulus, compared on every cycle.

// File: rtl/clb_pkg.sv
package clb_pkg;
  localparam int LUT_IN    = 4;
  localparam int LUT_DEPTH = 1 << LUT_IN;
  localparam int H_IN      = 3;
  localparam int H_DEPTH   = 1 << H_IN;
  localparam int N_ELEM    = 2;
  localparam int ELEM_BITS = 6;

  localparam int F_BASE    = 0;
  localparam int G_BASE    = F_BASE + LUT_DEPTH;
  localparam int H_BASE    = G_BASE + LUT_DEPTH;
  localparam int F_RAM_BIT = H_BASE + H_DEPTH;
  localparam int G_RAM_BIT = F_RAM_BIT + 1;
  localparam int X_H_BIT   = F_RAM_BIT + 2;
  localparam int Y_H_BIT   = F_RAM_BIT + 3;
  localparam int ELEM_BASE = F_RAM_BIT + 4;
  localparam int CFG_W     = ELEM_BASE + N_ELEM * ELEM_BITS;

  typedef enum logic [1:0] {
    SRC_DIN = 2'd0,
    SRC_F   = 2'd1,
    SRC_G   = 2'd2,
    SRC_H   = 2'd3
  } src_e;

  typedef struct packed {
    logic sr_val;
    logic sr_async;
    src_e src;
    logic clk_inv;
    logic latch;
  } elem_cfg_t;
endpackage

// File: rtl/clb_cfg_store.sv
module clb_cfg_store
  import clb_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_load,
  input  logic                 cfg_sdi,
  input  logic                 cfg_commit,
  input  logic                 we,
  input  logic                 din,
  input  logic [LUT_IN-1:0]    f_addr,
  input  logic [LUT_IN-1:0]    g_addr,
  output logic [CFG_W-1:0]     shadow,
  output logic [CFG_W-1:0]     active
);
  logic [CFG_W-1:0] shadow_nx;
  logic [CFG_W-1:0] active_nx;

  always_comb begin
    shadow_nx = shadow;
    if (cfg_load) shadow_nx = {cfg_sdi, shadow[CFG_W-1:1]};
  end

  always_comb begin
    active_nx = active;
    if (cfg_commit) begin
      active_nx = shadow;
    end else if (we) begin
      if (active[F_RAM_BIT]) active_nx[F_BASE + int'(f_addr)] = din;
      if (active[G_RAM_BIT]) active_nx[G_BASE + int'(g_addr)] = din;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow <= '0;
      active <= '0;
    end else begin
      shadow <= shadow_nx;
      active <= active_nx;
    end
  end
endmodule

// File: rtl/clb_lut_read.sv
module clb_lut_read #(
  parameter int N_IN = 4,
  localparam int DEPTH = 1 << N_IN
) (
  input  logic [DEPTH-1:0] table_bits,
  input  logic [N_IN-1:0]  sel,
  output logic             result
);
  always_comb result = table_bits[sel];
endmodule

// File: rtl/clb_store_elem.sv
module clb_store_elem
  import clb_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  elem_cfg_t cfg,
  input  logic      fab_clk,
  input  logic      fab_clk_prev,
  input  logic      clk_en,
  input  logic      sr,
  input  logic      din,
  input  logic      f_val,
  input  logic      g_val,
  input  logic      h_val,
  output logic      q_out
);
  logic q_reg;
  logic q_nx;
  logic level_on;
  logic edge_hit;
  logic data_sel;
  logic data_eff;
  logic async_hit;
  logic sync_hit;
  logic open_now;

  always_comb begin
    level_on  = fab_clk ^ cfg.clk_inv;
    edge_hit  = level_on & ~(fab_clk_prev ^ cfg.clk_inv);
    async_hit = sr & cfg.sr_async;
    sync_hit  = sr & ~cfg.sr_async;
    unique case (cfg.src)
      SRC_DIN: data_sel = din;
      SRC_F:   data_sel = f_val;
      SRC_G:   data_sel = g_val;
      default: data_sel = h_val;
    endcase
    data_eff = sync_hit ? cfg.sr_val : data_sel;
    open_now = cfg.latch & level_on & clk_en;
  end

  always_comb begin
    q_nx = q_reg;
    if (async_hit) begin
      q_nx = cfg.sr_val;
    end else if (cfg.latch) begin
      if (open_now) q_nx = data_eff;
    end else if (edge_hit && clk_en) begin
      q_nx = data_eff;
    end
  end

  always_comb begin
    if (async_hit)     q_out = cfg.sr_val;
    else if (open_now) q_out = data_eff;
    else               q_out = q_reg;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_reg <= 1'b0;
    else        q_reg <= q_nx;
  end
endmodule

// File: rtl/clb_dual_lut.sv
module clb_dual_lut
  import clb_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_load,
  input  logic              cfg_sdi,
  input  logic              cfg_commit,
  input  logic [LUT_IN-1:0] f_in,
  input  logic [LUT_IN-1:0] g_in,
  input  logic              h_in,
  input  logic              ram_din,
  input  logic              ram_we,
  input  logic              fab_clk,
  input  logic              clk_en,
  input  logic              sr,
  output logic              x,
  output logic              y,
  output logic              xq,
  output logic              yq
);
  logic [1:0]       rst_pipe;
  logic             rst_sync_n;
  logic             fab_clk_prev;
  logic [CFG_W-1:0] shadow;
  logic [CFG_W-1:0] active;
  logic             f_val;
  logic             g_val;
  logic             h_val;
  logic [N_ELEM-1:0] q_vec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) fab_clk_prev <= 1'b0;
    else             fab_clk_prev <= fab_clk;
  end

  clb_cfg_store u_cfg (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .cfg_load   (cfg_load),
    .cfg_sdi    (cfg_sdi),
    .cfg_commit (cfg_commit),
    .we         (ram_we),
    .din        (ram_din),
    .f_addr     (f_in),
    .g_addr     (g_in),
    .shadow     (shadow),
    .active     (active)
  );

  clb_lut_read #(.N_IN(LUT_IN)) u_f (
    .table_bits (active[F_BASE +: LUT_DEPTH]),
    .sel        (f_in),
    .result     (f_val)
  );

  clb_lut_read #(.N_IN(LUT_IN)) u_g (
    .table_bits (active[G_BASE +: LUT_DEPTH]),
    .sel        (g_in),
    .result     (g_val)
  );

  clb_lut_read #(.N_IN(H_IN)) u_h (
    .table_bits (active[H_BASE +: H_DEPTH]),
    .sel        ({h_in, g_val, f_val}),
    .result     (h_val)
  );

  assign x = active[X_H_BIT] ? h_val : f_val;
  assign y = active[Y_H_BIT] ? h_val : g_val;

  for (genvar e = 0; e < N_ELEM; e++) begin : g_elem
    elem_cfg_t ecfg;
    assign ecfg = elem_cfg_t'(active[ELEM_BASE + e*ELEM_BITS +: ELEM_BITS]);
    clb_store_elem u_se (
      .clk          (clk),
      .rst_n        (rst_sync_n),
      .cfg          (ecfg),
      .fab_clk      (fab_clk),
      .fab_clk_prev (fab_clk_prev),
      .clk_en       (clk_en),
      .sr           (sr),
      .din          (ram_din),
      .f_val        (f_val),
      .g_val        (g_val),
      .h_val        (h_val),
      .q_out        (q_vec[e])
    );
  end

  assign xq = q_vec[0];
  assign yq = q_vec[1];
endmodule

// File: rtl/clb_dual_lut_chk.sv
module clb_dual_lut_chk
  import clb_pkg::*;
(
  input logic              clk,
  input logic              rst_sync_n,
  input logic              cfg_load,
  input logic              cfg_commit,
  input logic              ram_we,
  input logic              ram_din,
  input logic [LUT_IN-1:0] f_in,
  input logic [CFG_W-1:0]  shadow,
  input logic [CFG_W-1:0]  active,
  input logic              fab_clk,
  input logic              fab_clk_prev,
  input logic              clk_en,
  input logic              sr,
  input logic              xq,
  input logic              yq
);
  localparam int E0 = ELEM_BASE;
  localparam int E1 = ELEM_BASE + ELEM_BITS;

  p_shadow_hold_r1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !cfg_load |=> $stable(shadow));

  p_commit_copy_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    cfg_commit |=> active == $past(shadow));

  p_active_hold_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!cfg_commit && !ram_we) |=> $stable(active));

  p_ram_write_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!cfg_commit && ram_we && active[F_RAM_BIT]) |=>
      active[F_BASE + int'($past(f_in))] == $past(ram_din));

  p_async_x_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (sr && active[E0+4]) |-> xq == active[E0+5]);

  p_async_y_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (sr && active[E1+4]) |-> yq == active[E1+5]);

  p_ff_hold_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!active[E0] && !cfg_commit && !(sr && active[E0+4]) &&
     ((fab_clk == fab_clk_prev) || !clk_en)) |=> (sr || $stable(xq)));
endmodule

bind clb_dual_lut clb_dual_lut_chk u_chk (
  .clk          (clk),
  .rst_sync_n   (rst_sync_n),
  .cfg_load     (cfg_load),
  .cfg_commit   (cfg_commit),
  .ram_we       (ram_we),
  .ram_din      (ram_din),
  .f_in         (f_in),
  .shadow       (shadow),
  .active       (active),
  .fab_clk      (fab_clk),
  .fab_clk_prev (fab_clk_prev),
  .clk_en       (clk_en),
  .sr           (sr),
  .xq           (xq),
  .yq           (yq)
);

// File: tb/test_clb_dual_lut.sv
module test_clb_dual_lut;
  localparam int PERIOD = 10;
  localparam int W = 56;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_load = 0, cfg_sdi = 0, cfg_commit = 0;
  logic [3:0] f_in = 0, g_in = 0;
  logic h_in = 0, ram_din = 0, ram_we = 0, fab_clk = 0, clk_en = 0, sr = 0;
  logic x, y, xq, yq;

  int n_run = 0, n_fail = 0;
  bit done = 0;

  logic [W-1:0] m_sh, m_act;
  logic m_kp;
  logic [1:0] m_q;

  always #(PERIOD/2) clk = ~clk;

  clb_dual_lut i_clb_dual_lut (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_sdi(cfg_sdi),
    .cfg_commit(cfg_commit), .f_in(f_in), .g_in(g_in), .h_in(h_in),
    .ram_din(ram_din), .ram_we(ram_we), .fab_clk(fab_clk), .clk_en(clk_en),
    .sr(sr), .x(x), .y(y), .xq(xq), .yq(yq)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %b expected %b", tag, $time, act, exp);
    end
  endtask

  // Behavioural reference: outputs from current model state and inputs
  task automatic model_eval(output logic ex, output logic ey,
                            output logic [1:0] eq, output logic [1:0] nq);
    logic fv, gv, hv, lvl, edg, d, srv;
    int base;
    fv = m_act[f_in];
    gv = m_act[16 + g_in];
    hv = m_act[32 + {h_in, gv, fv}];
    ex = m_act[42] ? hv : fv;
    ey = m_act[43] ? hv : gv;
    for (int e = 0; e < 2; e++) begin
      base = 44 + 6*e;
      lvl = fab_clk ^ m_act[base+1];
      edg = lvl && !(m_kp ^ m_act[base+1]);
      case (m_act[base+2 +: 2])
        2'd0: d = ram_din;
        2'd1: d = fv;
        2'd2: d = gv;
        default: d = hv;
      endcase
      srv = m_act[base+5];
      if (sr && !m_act[base+4]) d = srv;
      if (sr && m_act[base+4]) begin
        eq[e] = srv; nq[e] = srv;
      end else if (m_act[base]) begin
        eq[e] = (lvl && clk_en) ? d : m_q[e];
        nq[e] = eq[e];
      end else begin
        eq[e] = m_q[e];
        nq[e] = (edg && clk_en) ? d : m_q[e];
      end
    end
  endtask

  task automatic step();
    logic ex, ey;
    logic [1:0] eq, nq;
    logic [W-1:0] na;
    #1;
    model_eval(ex, ey, eq, nq);
    chk("R1 R2 R3 R4 R5 (x)", x, ex);
    chk("R1 R2 R3 R4 R5 (y)", y, ey);
    chk("R6 R7 R8 R9 R10 (xq)", xq, eq[0]);
    chk("R6 R7 R8 R9 R10 (yq)", yq, eq[1]);
    na = m_act;
    if (cfg_commit) na = m_sh;
    else if (ram_we) begin
      if (m_act[40]) na[f_in] = ram_din;
      if (m_act[41]) na[16 + g_in] = ram_din;
    end
    if (cfg_load) m_sh = {cfg_sdi, m_sh[W-1:1]};
    m_act = na;
    m_q = nq;
    m_kp = fab_clk;
    @(negedge clk);
  endtask

  task automatic rand_inputs(input bit allow_we);
    f_in = 4'($urandom());
    g_in = 4'($urandom());
    h_in = 1'($urandom());
    ram_din = 1'($urandom());
    ram_we = allow_we ? ($urandom() % 3 == 0) : 1'b0;
    clk_en = ($urandom() % 4 != 0);
    sr = ($urandom() % 8 == 0);
    if ($urandom() % 4 == 0) fab_clk = ~fab_clk;
  endtask

  task automatic load_cfg(input logic [W-1:0] word);
    for (int i = 0; i < W; i++) begin
      rand_inputs(1'b0);
      cfg_load = 1; cfg_sdi = word[i];
      step();
    end
    cfg_load = 0; cfg_sdi = 0;
    rand_inputs(1'b0);
    cfg_commit = 1;
    step();
    cfg_commit = 0;
  endtask

  task automatic run_random(input int n);
    for (int i = 0; i < n; i++) begin
      rand_inputs(1'b1);
      step();
    end
  endtask

  function automatic logic [W-1:0] mk(input logic [15:0] ft, input logic [15:0] gt,
      input logic [7:0] ht, input logic fr, input logic gr, input logic xh,
      input logic yh, input logic [5:0] e0, input logic [5:0] e1);
    return {e1, e0, yh, xh, gr, fr, ht, gt, ft};
  endfunction

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    m_sh = '0; m_act = '0; m_kp = 0; m_q = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R11: reset state, all outputs low with config zero
    f_in = 4'hF; g_in = 4'hF; h_in = 1; #1;
    chk("R11 (x)", x, 1'b0);
    chk("R11 (y)", y, 1'b0);
    chk("R11 (xq)", xq, 1'b0);
    chk("R11 (yq)", yq, 1'b0);
    @(negedge clk);
    // A: logic mode, FF rising from H with sync reset; latch from DIN with async set
    load_cfg(mk(16'h8000, 16'h6996, 8'hCA, 0, 0, 0, 1, 6'b001100, 6'b110001));
    run_random(300);
    // B: RAM mode on both tables, inverted polarities
    load_cfg(mk(16'h0000, 16'hFFFF, 8'hE8, 1, 1, 1, 0, 6'b010111, 6'b101010));
    run_random(300);
    // C: G as RAM only, F logic; FF from DIN with async set, latch from H with sync reset
    load_cfg(mk(16'hFFFE, 16'h1234, 8'h96, 0, 1, 1, 1, 6'b110000, 6'b001101));
    run_random(300);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule